// File: doc/BRIEF.md
# Four-Channel Offset Null Sequencer

This block is the digital controller behind an offset auto-null of four amplifier channels. Every channel owns an 8-bit correction code that feeds that channel's calibration DAC, plus a one-bit comparator result giving the sign of the residual offset. One shared sequencer walks all four successive-approximation searches together, bit by bit from the most significant bit down. All channels therefore finish on the same cycle, and the run length does not depend on the offsets found.

A run starts in one of three ways. Power-on reset starts one, and that run first waits a supply-settling interval. A rising edge on the asynchronous calibration pin starts one, as does a one-cycle command strobe from the test port. For the whole run the block holds a clamp high, which forces the analog outputs to zero. The clamp falling is the only sign that the run is over, and `busy` is a copy of it. Triggers that arrive during a run have no effect. The codes live only in registers and are rebuilt from zero on every run.

Top module: `offset_cal_seq`

## Requirements
- R1: While `rst` is high, `clamp` and `busy` are 1 and every channel code is mid-scale (0x80 for 8-bit codes).
- R2: After `rst` falls, the power-on run waits POR_WAIT cycles and then searches. `busy` stays high for POR_WAIT + CODE_W*(SETTLE+2) - 1 falling clock edges, counted from the first falling edge after the release.
- R3: A `cal_cmd` strobe sampled on a rising edge while idle raises `clamp` on that edge. `clamp` stays high for exactly CODE_W*(SETTLE+2) cycles.
- R4: A rising level on `cal_pin` passes through a two-flop synchronizer and an edge detector, so `clamp` rises on the third rising clock edge after the pin goes high. Holding the pin high starts no further run.
- R5: Each channel's search runs MSB first. It sets the trial bit, waits SETTLE cycles, samples that channel's `cmp_hi` bit (1 = trial code above target), and clears the bit when `cmp_hi` is 1. For a comparator that reports `code > target`, the final code equals the target. Channel i uses `dac_code[i*8 +: 8]` and `cmp_hi[i]`.
- R6: Targets 0x00 and 0xFF, and the codes on either side of mid-scale, are all reached exactly.
- R7: A `cal_cmd` strobe or `cal_pin` edge that arrives during any run, including the power-on wait, neither lengthens that run nor starts another.
- R8: Between runs the codes hold, whatever the comparators report. Each new run rebuilds every code from zero.
- R9: At clock rate CLK_HZ, a pin- or command-started run lasts under 100 ms, and a power-on run lasts under 250 ms.
- R10: `busy` equals `clamp` on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; its release starts the power-on run |
| cal_pin | input | 1 | Asynchronous external calibration request, acts on its rising edge |
| cal_cmd | input | 1 | One-cycle calibration strobe from the test port, same clock domain |
| cmp_hi | input | NUM_CH | Per-channel comparator: 1 when the trial code is above the channel's null point |
| dac_code | output | NUM_CH*CODE_W | Packed per-channel calibration codes, channel i at bits [i*CODE_W +: CODE_W] |
| clamp | output | 1 | Forces all amplifier outputs to zero while a run is active |
| busy | output | 1 | Copy of `clamp` for observing run boundaries |

## Verification
The assertions assume that `cal_cmd` is a single-cycle strobe in the block's clock domain. They also assume that each `cmp_hi` bit is a monotone function of its own channel's code, which keeps the sample-only-clears and hold properties meaningful. The bench models each comparator as a combinational `code > target` compare, so it meets both assumptions. It raises `cal_cmd` for exactly one clock. It holds `cal_pin` steady for many cycles, so the synchronizer never sees a pulse shorter than its two stages.

// File: rtl/offset_cal_pkg.sv
package offset_cal_pkg;

  // Sequencer states shared by the controller and its checks
  typedef enum logic [2:0] {
    ST_POR    = 3'd0,
    ST_IDLE   = 3'd1,
    ST_SET    = 3'd2,
    ST_SETTLE = 3'd3,
    ST_SAMPLE = 3'd4
  } cal_st_e;

  // Cycles per bit: trial, settle window, sample
  function automatic int cycles_per_run(input int code_w, input int settle);
    return code_w * (settle + 2);
  endfunction

endpackage

// File: rtl/cal_trigger.sv
module cal_trigger #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic cmd_i,
  output logic trig_o
);

  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], pin_i};
      prev_q <= sync_q[SYNC_N-1];
    end
  end

  assign rise   = sync_q[SYNC_N-1] & ~prev_q;
  assign trig_o = rise | cmd_i;

  // R4: an edge on the synchronized pin produces exactly one trigger cycle
  a_r4_single_rise: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import offset_cal_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int SETTLE   = 4,
  parameter int POR_WAIT = 64,
  parameter int CLK_HZ   = 200_000_000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      trig_i,
  output logic                      clr_o,
  output logic                      set_o,
  output logic                      smp_o,
  output logic [$clog2(CODE_W)-1:0] bit_o,
  output logic                      clamp_o
);

  localparam int BIT_W   = $clog2(CODE_W);
  localparam int CNT_MAX = (POR_WAIT > SETTLE) ? POR_WAIT : SETTLE;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [BIT_W-1:0] MSB_IDX  = BIT_W'(CODE_W - 1);
  localparam logic [CNT_W-1:0] POR_LAST = CNT_W'(POR_WAIT - 1);
  localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SETTLE - 1);
  localparam logic [31:0] POR_LIM = 32'(CLK_HZ / 4);   // 250 ms in cycles
  localparam logic [31:0] CMD_LIM = 32'(CLK_HZ / 10);  // 100 ms in cycles

  cal_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BIT_W-1:0] bit_q;
  logic             clamp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_POR;
      cnt_q   <= '0;
      bit_q   <= MSB_IDX;
      clamp_q <= 1'b1;
    end else begin
      case (st_q)
        ST_POR: begin
          if (cnt_q == POR_LAST) begin
            st_q  <= ST_SET;
            cnt_q <= '0;
            bit_q <= MSB_IDX;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_IDLE: begin
          if (trig_i) begin
            st_q    <= ST_SET;
            bit_q   <= MSB_IDX;
            clamp_q <= 1'b1;
          end
        end
        ST_SET: begin
          st_q  <= ST_SETTLE;
          cnt_q <= '0;
        end
        ST_SETTLE: begin
          if (cnt_q == SET_LAST) st_q <= ST_SAMPLE;
          else                   cnt_q <= cnt_q + 1'b1;
        end
        ST_SAMPLE: begin
          if (bit_q == '0) begin
            st_q    <= ST_IDLE;
            clamp_q <= 1'b0;
          end else begin
            bit_q <= bit_q - 1'b1;
            st_q  <= ST_SET;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign clr_o   = (st_q == ST_IDLE && trig_i) || (st_q == ST_POR && cnt_q == POR_LAST);
  assign set_o   = (st_q == ST_SET);
  assign smp_o   = (st_q == ST_SAMPLE);
  assign bit_o   = bit_q;
  assign clamp_o = clamp_q;

  // Run-length watch for the duration bounds
  logic [31:0] run_q;
  logic        por_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      por_q <= 1'b1;
    end else if (clamp_q) begin
      run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
      por_q <= 1'b0;
    end
  end

  // R9: each run ends within its time budget
  a_r9_run_bounded: assert property (@(posedge clk) disable iff (rst)
    clamp_q |-> (run_q < (por_q ? POR_LIM : CMD_LIM)));

  // R7: a trigger during the settle window does not disturb the walk
  a_r7_busy_ignores_trig: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SETTLE && trig_i) |=> (st_q == ST_SETTLE || st_q == ST_SAMPLE));

  // R7: the power-on wait cannot be cut short by a trigger
  a_r7_por_ignores_trig: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_POR && cnt_q != POR_LAST && trig_i) |=> st_q == ST_POR);

  // R3: an idle trigger raises the clamp on the next edge
  a_r3_start: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && trig_i) |=> clamp_q);

endmodule

// File: rtl/sar_channel.sv
module sar_channel #(
  parameter int CODE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr_i,
  input  logic                      set_i,
  input  logic                      smp_i,
  input  logic [$clog2(CODE_W)-1:0] bit_i,
  input  logic                      cmp_i,
  output logic [CODE_W-1:0]         code_o
);

  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst)                 code_q <= MID;
    else if (clr_i)          code_q <= '0;
    else if (set_i)          code_q[bit_i] <= 1'b1;
    else if (smp_i && cmp_i) code_q[bit_i] <= 1'b0;
  end

  assign code_o = code_q;

  // R5: a sample step never raises the code
  a_r5_sample_no_raise: assert property (@(posedge clk) disable iff (rst)
    smp_i |=> code_q <= $past(code_q));

  // R5: a trial step never lowers the code
  a_r5_trial_no_lower: assert property (@(posedge clk) disable iff (rst)
    set_i |=> code_q >= $past(code_q));

  // R8: with no sequencer step the code holds
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !(clr_i || set_i || smp_i) |=> $stable(code_q));

endmodule

// File: rtl/offset_cal_seq.sv
module offset_cal_seq
  import offset_cal_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int CODE_W   = 8,
  parameter int SETTLE   = 4,
  parameter int POR_WAIT = 64,
  parameter int CLK_HZ   = 200_000_000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cal_pin,
  input  logic                     cal_cmd,
  input  logic [NUM_CH-1:0]        cmp_hi,
  output logic [NUM_CH*CODE_W-1:0] dac_code,
  output logic                     clamp,
  output logic                     busy
);

  localparam int BIT_W = $clog2(CODE_W);

  logic             trig;
  logic             clr, set_s, smp;
  logic [BIT_W-1:0] bit_idx;
  logic             clamp_s;

  cal_trigger #(.SYNC_N(2)) u_trig (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (cal_pin),
    .cmd_i  (cal_cmd),
    .trig_o (trig)
  );

  cal_ctrl #(
    .CODE_W   (CODE_W),
    .SETTLE   (SETTLE),
    .POR_WAIT (POR_WAIT),
    .CLK_HZ   (CLK_HZ)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .trig_i  (trig),
    .clr_o   (clr),
    .set_o   (set_s),
    .smp_o   (smp),
    .bit_o   (bit_idx),
    .clamp_o (clamp_s)
  );

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    sar_channel #(.CODE_W(CODE_W)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .clr_i  (clr),
      .set_i  (set_s),
      .smp_i  (smp),
      .bit_i  (bit_idx),
      .cmp_i  (cmp_hi[gi]),
      .code_o (dac_code[gi*CODE_W +: CODE_W])
    );
  end

  assign clamp = clamp_s;
  assign busy  = clamp_s;

  // R1: reset holds the clamp on
  a_r1_reset_clamp: assert property (@(posedge clk) rst |=> clamp);

endmodule

// File: tb/offset_cal_seq_test.sv
`timescale 1ns/1ps
module offset_cal_seq_test;

  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam int STL = 4;
  localparam int PW  = 64;
  localparam int RUN = CW * (STL + 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cal_pin = 1'b0;
  logic cal_cmd = 1'b0;
  logic [NCH-1:0]    cmp_hi;
  logic [NCH*CW-1:0] dac_code;
  logic clamp, busy;
  logic [CW-1:0] tgt [NCH];

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  offset_cal_seq #(.NUM_CH(NCH), .CODE_W(CW), .SETTLE(STL), .POR_WAIT(PW)) uut (
    .clk(clk), .rst(rst), .cal_pin(cal_pin), .cal_cmd(cal_cmd),
    .cmp_hi(cmp_hi), .dac_code(dac_code), .clamp(clamp), .busy(busy)
  );

  // Comparator model: high when the trial code is above the null point
  always_comb begin
    for (int i = 0; i < NCH; i++) cmp_hi[i] = dac_code[i*CW +: CW] > tgt[i];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_codes(input string req);
    for (int i = 0; i < NCH; i++)
      check(dac_code[i*CW +: CW] == tgt[i], req, int'(dac_code[i*CW +: CW]), int'(tgt[i]));
  endtask

  task automatic wait_run(output int n);
    n = 0;
    while (busy) begin
      check(busy == clamp, "R10 busy mirrors clamp", int'(busy), int'(clamp));
      n++;
      @(negedge clk);
    end
  endtask

  task automatic idle_window(input int cyc, input string req);
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (busy) begin
        check(1'b0, req, 1, 0);
        break;
      end
    end
    check(!busy, req, int'(busy), 0);
  endtask

  task automatic cmd_pulse();
    @(negedge clk); cal_cmd = 1'b1;
    @(negedge clk); cal_cmd = 1'b0;
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    check(clamp == 1'b1 && busy == 1'b1, "R1 clamp during reset", int'(clamp), 1);
    for (int i = 0; i < NCH; i++)
      check(dac_code[i*CW +: CW] == 8'h80, "R1 mid-scale", int'(dac_code[i*CW +: CW]), 128);
  endtask

  task automatic t_por();
    int n = 0;
    rst = 1'b0;
    do begin
      @(negedge clk);
      cal_cmd = (n == 5);           // R7: strobe inside the power-on wait
      if (busy) n++;
    end while (busy);
    cal_cmd = 1'b0;
    check(n == PW + RUN - 1, "R2 power-on run length", n, PW + RUN - 1);
    check_codes("R5 power-on result");
    idle_window(10, "R7 no run after ignored strobe");
  endtask

  task automatic t_cmd();
    int n;
    tgt[0] = 8'd37; tgt[1] = 8'd200; tgt[2] = 8'd90; tgt[3] = 8'd161;
    cmd_pulse();
    check(busy == 1'b1, "R3 clamp rises after strobe", int'(busy), 1);
    wait_run(n);
    check(n == RUN, "R3 command run length", n, RUN);
    check_codes("R5 command result");
  endtask

  task automatic t_pin();
    int n;
    tgt[0] = 8'd5; tgt[1] = 8'd250; tgt[2] = 8'd129; tgt[3] = 8'd64;
    @(negedge clk); cal_pin = 1'b1;
    @(negedge clk); check(!busy, "R4 sync stage 1", int'(busy), 0);
    @(negedge clk); check(!busy, "R4 sync stage 2", int'(busy), 0);
    @(negedge clk); check(busy, "R4 clamp on third edge", int'(busy), 1);
    wait_run(n);
    check(n == RUN, "R4 pin run length", n, RUN);
    check_codes("R5 pin result");
    idle_window(20, "R4 held level no retrigger");
    cal_pin = 1'b0;
    idle_window(5, "R4 falling level no trigger");
  endtask

  task automatic t_retrig();
    int n = 0;
    tgt[0] = 8'd11; tgt[1] = 8'd22; tgt[2] = 8'd33; tgt[3] = 8'd44;
    cmd_pulse();
    while (busy) begin
      n++;
      cal_cmd = (n == 10);
      if (n == 20) cal_pin = 1'b1;
      @(negedge clk);
    end
    cal_cmd = 1'b0;
    check(n == RUN, "R7 run not extended", n, RUN);
    idle_window(10, "R7 no second run");
    cal_pin = 1'b0;
    check_codes("R7 result intact");
  endtask

  task automatic t_corner();
    int n;
    tgt[0] = 8'd0; tgt[1] = 8'd255; tgt[2] = 8'd128; tgt[3] = 8'd127;
    cmd_pulse();
    wait_run(n);
    check(n == RUN, "R6 corner run length", n, RUN);
    check_codes("R6 corner codes");
  endtask

  task automatic t_hold();
    int n;
    tgt[0] = 8'd0; tgt[1] = 8'd255; tgt[2] = 8'd128; tgt[3] = 8'd127;
    tgt[0] = 8'd99; tgt[1] = 8'd1; tgt[2] = 8'd254; tgt[3] = 8'd77;
    repeat (20) @(negedge clk);
    check(dac_code == {8'd127, 8'd128, 8'd255, 8'd0}, "R8 codes hold while idle",
          int'(dac_code[7:0]), 0);
    cmd_pulse();
    wait_run(n);
    check_codes("R8 recomputed on new run");
  endtask

  initial begin
    tgt[0] = 8'd17; tgt[1] = 8'd140; tgt[2] = 8'd255; tgt[3] = 8'd0;
    t_reset();
    t_por();
    t_cmd();
    t_pin();
    t_retrig();
    t_corner();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule